// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Controller

This block turns one PWM command into two gate-enable requests for a synchronous half-bridge: a high-side request that follows PWM and a low-side request that is its complement. The two switches are never requested together. Each hand-over between them waits for evidence that the switch going off really is off.

The two directions use different rules. On a falling PWM edge the high side is released first. The low side is requested only once a digitized comparator flag reports that the switch node has dropped below its low threshold. On a rising PWM edge the low side is released first. The block then waits for a flag reporting that the low-side gate has collapsed near its off level, and then for a further programmable number of clock cycles, before it requests the high side.

All four control inputs are asynchronous and pass through two-stage synchronizers. An optional timeout bounds each feedback wait. A timeout latches a fault that keeps both gates off until the block is disabled. Analog sensing and gate drive sit outside the block.

Top module: `dt_gate_ctrl`

## Requirements
- R1: Each of pwm_i, en_i, sw_low_i and ls_gate_low_i is sampled by two flip-flops before the state machine uses it. A change that is set up before rising edge k first affects the outputs after rising edge k+2.
- R2: hs_on_o and ls_on_o are never high in the same cycle.
- R3: When PWM falls while the high side is on, hs_on_o drops and the block waits in state 2. ls_on_o rises only after a synchronized sw_low_i is seen high in that state.
- R4: When PWM rises while the low side is on, ls_on_o drops and the block waits in state 4 for ls_gate_low_i. It then stays exactly DELAY_CYC cycles in state 5 before hs_on_o rises.
- R5: While the synchronized enable is low, the state is 0 and hs_on_o, ls_on_o and fault_o are all low.
- R6: A PWM reversal during a wait abandons the pending turn-on. State 2 with PWM high goes to state 4. State 4 or 5 with PWM low goes to state 3. A reversal takes priority over a feedback flag that arrives in the same cycle.
- R7: If state 2 or 4 lasts TIMEOUT_CYC cycles without its flag, fault_o goes high and the state becomes 0. Both requests then stay low and fault_o stays high until the enable goes low. A flag seen in the last cycle of the wait wins over the timeout.
- R8: From state 0 with enable high and no fault, PWM low leads to state 3 (low side on). PWM high leads to state 4, and then through the R4 sequence.
- R9: state_o encoding: 0 both off, 1 high side on, 2 waiting for switch node low, 3 low side on, 4 waiting for low-side gate low, 5 fixed delay before high side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command, asynchronous |
| en_i | input | 1 | Enable, asynchronous; low forces both gates off |
| sw_low_i | input | 1 | Switch node below low threshold |
| ls_gate_low_i | input | 1 | Low-side gate near off level |
| hs_on_o | output | 1 | High-side gate request (registered) |
| ls_on_o | output | 1 | Low-side gate request (registered) |
| fault_o | output | 1 | Feedback timeout latched |
| state_o | output | 3 | Current state code per R9 |

## Verification
Two events can arrive in the same cycle. A PWM reversal can coincide with the feedback flag that would complete the pending hand-over. A flag can also land on exactly the cycle in which the timeout expires. The bench raises PWM and sw_low_i at the same instant while the block waits for the switch node. It also sweeps the arrival of the gate flag across the cycles around the timeout limit. A behavioural reference model, fed the same pins through its own two-cycle input delay, predicts every cycle whether the reversal or the flag wins, and whether the flag or the timeout wins. Its prediction is compared with all outputs on every clock.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE_OFF         = 3'd0,
    ST_HS_ON            = 3'd1,
    ST_WAIT_SW_LOW      = 3'd2,
    ST_LS_ON            = 3'd3,
    ST_WAIT_LS_GATE_LOW = 3'd4,
    ST_DELAY_HS         = 3'd5
  } dt_state_e;
endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dt_timer.sv
module dt_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (run_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> cnt_q == '0); // R4
endmodule

// File: rtl/dt_fsm.sv
module dt_fsm
  import dt_pkg::*;
#(
  parameter int DELAY_CYC   = 3,
  parameter int TIMEOUT_CYC = 64,
  parameter bit TIMEOUT_EN  = 1'b1,
  parameter int CNT_W       = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             en_i,
  input  logic             sw_low_i,
  input  logic             gate_low_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output logic             run_o,
  output logic             hs_o,
  output logic             ls_o,
  output logic             fault_o,
  output dt_state_e        state_o
);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);

  dt_state_e state_q, state_d;
  logic      fault_q, fault_d;
  logic      hs_q, ls_q;
  logic      dly_hit, to_hit;

  assign dly_hit = (cnt_i == DLY_LAST);

  generate
    if (TIMEOUT_EN) begin : g_to
      localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);
      assign to_hit = (cnt_i == TO_LAST);
    end else begin : g_no_to
      assign to_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    if (!en_i) begin
      state_d = ST_IDLE_OFF;
      fault_d = 1'b0;
    end else if (fault_q) begin
      state_d = ST_IDLE_OFF;
    end else begin
      unique case (state_q)
        ST_IDLE_OFF: state_d = pwm_i ? ST_WAIT_LS_GATE_LOW : ST_LS_ON;
        ST_HS_ON: if (!pwm_i) state_d = ST_WAIT_SW_LOW;
        ST_WAIT_SW_LOW: begin
          if (pwm_i)         state_d = ST_WAIT_LS_GATE_LOW;
          else if (sw_low_i) state_d = ST_LS_ON;
          else if (to_hit) begin
            state_d = ST_IDLE_OFF;
            fault_d = 1'b1;
          end
        end
        ST_LS_ON: if (pwm_i) state_d = ST_WAIT_LS_GATE_LOW;
        ST_WAIT_LS_GATE_LOW: begin
          if (!pwm_i)          state_d = ST_LS_ON;
          else if (gate_low_i) state_d = ST_DELAY_HS;
          else if (to_hit) begin
            state_d = ST_IDLE_OFF;
            fault_d = 1'b1;
          end
        end
        ST_DELAY_HS: begin
          if (!pwm_i)       state_d = ST_LS_ON;
          else if (dly_hit) state_d = ST_HS_ON;
        end
        default: state_d = ST_IDLE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE_OFF;
      fault_q <= 1'b0;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
      hs_q    <= (state_d == ST_HS_ON);
      ls_q    <= (state_d == ST_LS_ON);
    end
  end

  assign clr_o   = (state_d != state_q);
  assign run_o   = (state_q == ST_WAIT_SW_LOW) || (state_q == ST_WAIT_LS_GATE_LOW) ||
                   (state_q == ST_DELAY_HS);
  assign hs_o    = hs_q;
  assign ls_o    = ls_q;
  assign fault_o = fault_q;
  assign state_o = state_q;

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q)); // R2
  AST_LS_AFTER_SW_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_q) && $past(state_q == ST_WAIT_SW_LOW) |-> $past(sw_low_i)); // R3
  AST_HS_AFTER_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(state_q == ST_DELAY_HS) && $past(pwm_i)); // R4
  AST_DISABLED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !hs_q && !ls_q && !fault_q); // R5
  AST_REVERSE_TO_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(state_q == ST_DELAY_HS) && $past(en_i) && !$past(pwm_i) |-> state_q == ST_LS_ON); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q && en_i |=> fault_q); // R7
  AST_FAULT_GATES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> !hs_q && !ls_q); // R7
endmodule

// File: rtl/dt_gate_ctrl.sv
module dt_gate_ctrl
  import dt_pkg::*;
#(
  parameter int DELAY_CYC   = 3,
  parameter int TIMEOUT_CYC = 64,
  parameter bit TIMEOUT_EN  = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwm_i,
  input  logic       en_i,
  input  logic       sw_low_i,
  input  logic       ls_gate_low_i,
  output logic       hs_on_o,
  output logic       ls_on_o,
  output logic       fault_o,
  output logic [2:0] state_o
);
  localparam int LIMIT = (DELAY_CYC > TIMEOUT_CYC) ? DELAY_CYC : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [3:0]       raw, syn;
  logic [CNT_W-1:0] cnt;
  logic             clr, run;
  dt_state_e        st;

  assign raw = {ls_gate_low_i, sw_low_i, en_i, pwm_i};

  dt_sync #(.WIDTH(4)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  dt_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .run_i (run),
    .cnt_o (cnt)
  );

  dt_fsm #(
    .DELAY_CYC  (DELAY_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .TIMEOUT_EN (TIMEOUT_EN),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwm_i     (syn[0]),
    .en_i      (syn[1]),
    .sw_low_i  (syn[2]),
    .gate_low_i(syn[3]),
    .cnt_i     (cnt),
    .clr_o     (clr),
    .run_o     (run),
    .hs_o      (hs_on_o),
    .ls_o      (ls_on_o),
    .fault_o   (fault_o),
    .state_o   (st)
  );

  assign state_o = st;
endmodule

// File: tb/dt_gate_ctrl_test.sv
module dt_gate_ctrl_test;
  localparam int DLY = 3;
  localparam int TO  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwm = 1'b0, en = 1'b0, swl = 1'b0, gl = 1'b0;
  logic hs, ls, flt;
  logic [2:0] st;

  int checks = 0, fails = 0;
  string cur_req = "R5";
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  dt_gate_ctrl #(.DELAY_CYC(DLY), .TIMEOUT_CYC(TO), .TIMEOUT_EN(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .en_i(en), .sw_low_i(swl),
    .ls_gate_low_i(gl), .hs_on_o(hs), .ls_on_o(ls), .fault_o(flt), .state_o(st)
  );

  // reference model: two-deep input history, then the hand-over rules
  int m_st, m_cnt;
  bit m_f;
  bit q1 [4];
  bit q2 [4];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_f = 0;
      for (int i = 0; i < 4; i++) begin q1[i] = 0; q2[i] = 0; end
    end else begin
      int nst;
      bit nf, p, e, s, g;
      p = q2[0]; e = q2[1]; s = q2[2]; g = q2[3];
      nst = m_st; nf = m_f;
      if (!e) begin nst = 0; nf = 0; end
      else if (m_f) nst = 0;
      else begin
        if (m_st == 0) nst = p ? 4 : 3;
        else if (m_st == 1) begin if (!p) nst = 2; end
        else if (m_st == 2) begin
          if (p) nst = 4; else if (s) nst = 3;
          else if (m_cnt == TO - 1) begin nst = 0; nf = 1; end
        end
        else if (m_st == 3) begin if (p) nst = 4; end
        else if (m_st == 4) begin
          if (!p) nst = 3; else if (g) nst = 5;
          else if (m_cnt == TO - 1) begin nst = 0; nf = 1; end
        end
        else if (m_st == 5) begin
          if (!p) nst = 3; else if (m_cnt == DLY - 1) nst = 1;
        end
      end
      if (nst != m_st) m_cnt = 0;
      else if (m_st == 2 || m_st == 4 || m_st == 5) m_cnt = m_cnt + 1;
      m_st = nst; m_f = nf;
      q2 = q1;
      q1[0] = pwm; q1[1] = en; q1[2] = swl; q1[3] = gl;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      bit ehs, els;
      ehs = (m_st == 1); els = (m_st == 3);
      checks++;
      if (hs !== ehs || ls !== els || flt !== m_f || st !== 3'(m_st)) begin
        fails++;
        $display("FAIL %s t=%0t hs/ls/fault/state = %0b/%0b/%0b/%0d expected %0b/%0b/%0b/%0d",
                 cur_req, $time, hs, ls, flt, st, ehs, els, m_f, m_st);
      end
      checks++;
      if (hs && ls) begin
        fails++;
        $display("FAIL R2 both requests high: hs=%0b ls=%0b expected not both", hs, ls);
      end
    end
  end

  task automatic drive(input bit p, input bit e, input bit s, input bit g);
    @(posedge clk); #5;
    pwm = p; en = e; swl = s; gl = g;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R1) actual=hung expected=finished");
    report();
  end

  initial begin
    // R5: reset and disabled state
    cyc(3);
    rst_ni = 1'b1;
    cyc(4);
    checks++;
    if (st !== 3'd0 || hs || ls || flt) begin
      fails++;
      $display("FAIL R5 reset state=%0d hs=%0b ls=%0b expected 0/0/0", st, hs, ls);
    end
    // R8, R1: enable with PWM low, latency observed by the per-cycle compare
    cur_req = "R1";
    drive(0, 1, 0, 0); cyc(6);
    cur_req = "R8";
    cyc(2);
    // R4: rising hand-over, late gate flag
    cur_req = "R4";
    drive(1, 1, 0, 0); cyc(6);
    drive(1, 1, 0, 1); cyc(10);
    // R3: falling hand-over, late switch-node flag
    cur_req = "R3";
    drive(0, 1, 0, 1); cyc(7);
    drive(0, 1, 1, 1); cyc(6);
    // R6: reversal while waiting for gate flag
    cur_req = "R6";
    drive(1, 1, 1, 0); cyc(5);
    drive(0, 1, 1, 0); cyc(6);
    // R6: reversal during fixed delay
    drive(1, 1, 0, 1); cyc(4);
    drive(0, 1, 0, 1); cyc(6);
    // R6: reversal and sw flag in the same cycle while waiting for switch node
    drive(1, 1, 0, 1); cyc(10);
    drive(0, 1, 0, 1); cyc(5);
    drive(1, 1, 1, 1); cyc(10);
    // R7: timeout on gate flag, PWM activity ignored while faulted
    cur_req = "R7";
    drive(0, 1, 1, 1); cyc(6);
    drive(1, 1, 0, 0); cyc(TO + 6);
    drive(0, 1, 1, 1); cyc(6);
    drive(1, 1, 1, 1); cyc(6);
    // R5: disable clears fault
    cur_req = "R5";
    drive(1, 0, 0, 0); cyc(6);
    // R8: re-enable with PWM high goes through gate check and delay
    cur_req = "R8";
    drive(1, 1, 0, 0); cyc(5);
    drive(1, 1, 0, 1); cyc(8);
    // R5: disable while high side on
    cur_req = "R5";
    drive(1, 0, 0, 1); cyc(6);
    drive(0, 1, 1, 1); cyc(6);
    // R7: flag arrival swept across the timeout boundary, both waits
    cur_req = "R7";
    for (int d = TO - 4; d <= TO + 2; d++) begin
      drive(1, 1, 1, 0); cyc(d);
      drive(1, 1, 0, 1); cyc(8);
      drive(0, 1, 0, 1); cyc(d);
      drive(0, 1, 1, 1); cyc(6);
      drive(0, 0, 1, 1); cyc(4);
      drive(0, 1, 1, 1); cyc(6);
    end
    // R9, R2: pseudo-random traffic
    cur_req = "R9";
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] ^ lfsr[5], !(lfsr[3:1] == 3'b000 && lfsr[9]), lfsr[7], lfsr[11]);
    end
    cyc(4);
    report();
  end
endmodule